// File: doc/BRIEF.md
# Weighted Round-Robin Output Queue Scheduler

This block chooses which of the output queues of one port may send next. Each queue has a small priority setting. The setting is expanded into an eight-bit round mask whose set bits are spread across the rounds, so that service is interleaved and does not come in bursts. A three-bit round counter selects one mask bit. A non-empty queue takes part in the current round when its bit for that round is set, and it is served at most once per round. Within a round, a rotating pointer chooses among the eligible queues. The search starts one place after the queue that last received a weighted grant.

Queues given the static setting form a strict-priority group only when they are contiguous from queue 0. A non-empty member of that group pre-empts every weighted queue, and the lowest index wins. The grant is registered. It stays on the outputs until the consumer pulses the accept strobe, and a new decision is made only in a cycle where no grant is pending or the pending one is being accepted. Priority settings may change at any time and take effect at the next decision.

Top module: `wrr_sched`

## Requirements
- R1: While reset is asserted and after it is released, `grant_valid` is 0 until a decision has found a candidate.
- R2: The priority level maps to a round mask (bit r = round r): 0→0x00, 1→0x01, 2→0x11, 3→0x49, 4→0x55, 5→0x57, 6→0x77, 7→0x7f, 8→0xff, and any value of 9 or above → 0xff. A level-8 queue therefore receives about eight times the grants of a level-1 queue.
- R3: A queue at level 0 that is not in the static group is never granted.
- R4: Queue q is static when its level is 9 and all queues below q are also at level 9. When any static queue is non-empty, the lowest-indexed non-empty static queue is granted. Static grants change neither the round, the pointer nor the served set.
- R5: A level-9 queue that is not part of the contiguous group starting at queue 0 is scheduled as a weighted queue with mask 0xff.
- R6: Among the weighted queues eligible in a round, the grant goes to the first one found at or after index (last weighted grant + 1), wrapping around. After reset the pointer is NQ-1, so the search starts at queue 0.
- R7: Each weighted queue is granted at most once per round. When a decision finds no eligible weighted queue and no static candidate, but some non-empty weighted queue has a non-zero mask, no grant is issued in that cycle, the round advances by one (modulo 8) and the served set clears.
- R8: When no non-empty weighted queue has a non-zero mask and no static queue is non-empty, `grant_valid` stays 0 and the round counter holds.
- R9: While `grant_valid` is 1 and `grant_ack` is 0, `grant_valid` and `grant_qid` hold their values.
- R10: A decision is taken at a clock edge where no grant is pending or `grant_ack` is 1. It uses the inputs sampled at that edge, and its result appears on the outputs after that same edge.
- R11: A priority change takes effect at the next decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| queue_prio | input | NQ*4 | Per-queue priority level; queue q uses bits [4q+3:4q] |
| q_nonempty | input | NQ | Per-queue has-work flags |
| grant_ack | input | 1 | Accepts the pending grant |
| grant_valid | output | 1 | A grant is pending |
| grant_qid | output | $clog2(NQ) | Index of the granted queue |

## Verification
The assertions assume that the priority and non-empty inputs are steady around the clock edge, and that `grant_ack` is only used as a handshake with a pending grant. An accept with no grant pending is harmless, because a decision is taken in that cycle anyway. The bench changes every input at the falling edge only. It mixes fully random levels, contiguous and broken static prefixes and random accept strobes with directed phases: equal weights, a held grant, idle conditions, a live priority change and a weight-ratio sweep. A reference model in the bench, built from the rules above, predicts the output for every cycle.

// File: rtl/wrr_pkg.sv
package wrr_pkg;
    localparam int ROUNDS     = 8;
    localparam int RND_W      = 3;
    localparam int PRIO_W     = 4;
    localparam logic [PRIO_W-1:0] PRIO_STATIC = 4'd9;

    // Spread the level's set bits evenly across the eight rounds.
    function automatic logic [ROUNDS-1:0] level_mask(input logic [PRIO_W-1:0] lvl);
        case (lvl)
            4'd0:    level_mask = 8'h00;
            4'd1:    level_mask = 8'h01;
            4'd2:    level_mask = 8'h11;
            4'd3:    level_mask = 8'h49;
            4'd4:    level_mask = 8'h55;
            4'd5:    level_mask = 8'h57;
            4'd6:    level_mask = 8'h77;
            4'd7:    level_mask = 8'h7f;
            default: level_mask = 8'hff;
        endcase
    endfunction
endpackage

// File: rtl/wrr_prio_decode.sv
module wrr_prio_decode
    import wrr_pkg::*;
#(
    parameter int NQ = 16
) (
    input  logic [NQ*PRIO_W-1:0] prio_flat,
    output logic [NQ*ROUNDS-1:0] mask_flat,
    output logic [NQ-1:0]        is_static
);
    logic [NQ:0] prefix_ok;
    assign prefix_ok[0] = 1'b1;

    genvar q;
    generate
        for (q = 0; q < NQ; q++) begin : g_q
            logic [PRIO_W-1:0] lvl;
            assign lvl                         = prio_flat[q*PRIO_W +: PRIO_W];
            assign mask_flat[q*ROUNDS +: ROUNDS] = level_mask(lvl);
            assign is_static[q]                = prefix_ok[q] && (lvl == PRIO_STATIC);
            assign prefix_ok[q+1]              = is_static[q];
        end
    endgenerate
endmodule

// File: rtl/wrr_rot_pick.sv
module wrr_rot_pick #(
    parameter int N  = 16,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] last,
    output logic          hit,
    output logic [IW-1:0] idx
);
    // Scan from far to near so the nearest request after 'last' wins.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            int j;
            j = (int'(last) + 1 + i) % N;
            if (req[j]) begin
                hit = 1'b1;
                idx = j[IW-1:0];
            end
        end
    end
endmodule

// File: rtl/wrr_sched.sv
module wrr_sched
    import wrr_pkg::*;
#(
    parameter int NQ = 16,
    localparam int QW = $clog2(NQ)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NQ*PRIO_W-1:0] queue_prio,
    input  logic [NQ-1:0]        q_nonempty,
    input  logic                 grant_ack,
    output logic                 grant_valid,
    output logic [QW-1:0]        grant_qid
);
    typedef struct packed {
        logic             valid;
        logic [QW-1:0]    qid;
        logic [QW-1:0]    ptr;
        logic [RND_W-1:0] round;
        logic [NQ-1:0]    served;
    } state_t;

    state_t st_q, st_d;

    logic [NQ*ROUNDS-1:0] mask_flat;
    logic [NQ-1:0]        is_static;
    logic [NQ-1:0]        in_round;
    logic [NQ-1:0]        has_mask;
    logic [NQ-1:0]        wt_req;
    logic                 st_hit, wt_hit;
    logic [QW-1:0]        st_idx, wt_idx;

    wrr_prio_decode #(.NQ(NQ)) u_dec (
        .prio_flat (queue_prio),
        .mask_flat (mask_flat),
        .is_static (is_static)
    );

    genvar q;
    generate
        for (q = 0; q < NQ; q++) begin : g_elig
            assign in_round[q] = mask_flat[q*ROUNDS + int'(st_q.round)];
            assign has_mask[q] = |mask_flat[q*ROUNDS +: ROUNDS];
        end
    endgenerate

    assign wt_req = ~is_static & q_nonempty & in_round & ~st_q.served;

    // Static group: fixed scan from queue 0.
    wrr_rot_pick #(.N(NQ)) u_static_pick (
        .req  (is_static & q_nonempty),
        .last (QW'(NQ - 1)),
        .hit  (st_hit),
        .idx  (st_idx)
    );

    // Weighted group: rotating scan after the last weighted grant.
    wrr_rot_pick #(.N(NQ)) u_wt_pick (
        .req  (wt_req),
        .last (st_q.ptr),
        .hit  (wt_hit),
        .idx  (wt_idx)
    );

    always_comb begin
        logic decide;
        logic any_cand;
        st_d     = st_q;
        decide   = !st_q.valid || grant_ack;
        any_cand = |(~is_static & q_nonempty & has_mask);
        if (decide) begin
            st_d.valid = 1'b0;
            if (st_hit) begin
                st_d.valid = 1'b1;
                st_d.qid   = st_idx;
            end else if (wt_hit) begin
                st_d.valid          = 1'b1;
                st_d.qid            = wt_idx;
                st_d.ptr            = wt_idx;
                st_d.served[wt_idx] = 1'b1;
            end else if (any_cand) begin
                st_d.round  = st_q.round + 1'b1;
                st_d.served = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.valid  <= 1'b0;
            st_q.qid    <= '0;
            st_q.ptr    <= QW'(NQ - 1);
            st_q.round  <= '0;
            st_q.served <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_valid = st_q.valid;
    assign grant_qid   = st_q.qid;
endmodule

// File: rtl/wrr_sched_chk.sv
module wrr_sched_chk
    import wrr_pkg::*;
#(
    parameter int NQ = 16,
    localparam int QW = $clog2(NQ)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NQ*PRIO_W-1:0] queue_prio,
    input logic [NQ-1:0]        q_nonempty,
    input logic                 grant_ack,
    input logic                 grant_valid,
    input logic [QW-1:0]        grant_qid
);
    logic [NQ*PRIO_W-1:0] prev_prio;
    logic [NQ-1:0]        prev_ne;
    logic                 prev_decide;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_prio   <= '0;
            prev_ne     <= '0;
            prev_decide <= 1'b1;
        end else begin
            prev_prio   <= queue_prio;
            prev_ne     <= q_nonempty;
            prev_decide <= !grant_valid || grant_ack;
        end
    end

    logic new_grant;
    assign new_grant = grant_valid && prev_decide;

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !grant_ack) |=> (grant_valid && $stable(grant_qid)));

    a_r10_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        new_grant |-> prev_ne[grant_qid]);

    a_r3_no_zero: assert property (@(posedge clk) disable iff (!rst_n)
        new_grant |-> (prev_prio[grant_qid*PRIO_W +: PRIO_W] != 4'd0));

    a_r4_static_first: assert property (@(posedge clk) disable iff (!rst_n)
        (new_grant && prev_ne[0] && prev_prio[PRIO_W-1:0] == PRIO_STATIC)
            |-> (grant_qid == '0));

    a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_decide && prev_ne == '0) |-> !grant_valid);
endmodule

bind wrr_sched wrr_sched_chk #(.NQ(NQ)) u_wrr_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .queue_prio  (queue_prio),
    .q_nonempty  (q_nonempty),
    .grant_ack   (grant_ack),
    .grant_valid (grant_valid),
    .grant_qid   (grant_qid)
);

// File: tb/tb_wrr_sched.sv
`timescale 1ns/1ps
module tb_wrr_sched;
    localparam int NQ = 16;
    localparam int QW = $clog2(NQ);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NQ*4-1:0]   queue_prio = '0;
    logic [NQ-1:0]     q_nonempty = '0;
    logic              grant_ack = 1'b0;
    logic              grant_valid;
    logic [QW-1:0]     grant_qid;

    always #2 clk = ~clk;

    wrr_sched #(.NQ(NQ)) dut (
        .clk(clk), .rst_n(rst_n), .queue_prio(queue_prio),
        .q_nonempty(q_nonempty), .grant_ack(grant_ack),
        .grant_valid(grant_valid), .grant_qid(grant_qid)
    );

    int errors = 0;
    int checks = 0;
    bit done = 0;
    string tag = "R1";

    // Reference model state
    bit          m_valid;
    int          m_qid, m_ptr, m_round;
    bit [NQ-1:0] m_served;

    function automatic bit [7:0] ref_mask(input int lvl);
        case (lvl)
            0: return 8'h00; 1: return 8'h01; 2: return 8'h11;
            3: return 8'h49; 4: return 8'h55; 5: return 8'h57;
            6: return 8'h77; 7: return 8'h7f; default: return 8'hff;
        endcase
    endfunction

    function automatic int lvl_of(input int q);
        return int'(queue_prio[q*4 +: 4]);
    endfunction

    function automatic bit ref_static(input int q);
        for (int k = 0; k <= q; k++) if (lvl_of(k) != 9) return 0;
        return 1;
    endfunction

    task automatic model_reset();
        m_valid = 0; m_qid = 0; m_ptr = NQ - 1; m_round = 0; m_served = '0;
    endtask

    task automatic model_step();
        int  pick;
        bit  cand;
        if (!(!m_valid || grant_ack)) return;
        m_valid = 0;
        pick = -1;
        for (int q = 0; q < NQ && pick < 0; q++)
            if (ref_static(q) && q_nonempty[q]) pick = q;
        if (pick >= 0) begin
            m_valid = 1; m_qid = pick;
            return;
        end
        for (int i = 1; i <= NQ && pick < 0; i++) begin
            int j;
            j = (m_ptr + i) % NQ;
            if (!ref_static(j) && q_nonempty[j] && !m_served[j] && ref_mask(lvl_of(j))[m_round])
                pick = j;
        end
        if (pick >= 0) begin
            m_valid = 1; m_qid = pick; m_ptr = pick; m_served[pick] = 1;
            return;
        end
        cand = 0;
        for (int q = 0; q < NQ; q++)
            if (!ref_static(q) && q_nonempty[q] && ref_mask(lvl_of(q)) != 0) cand = 1;
        if (cand) begin
            m_round = (m_round + 1) % 8; m_served = '0;
        end
    endtask

    task automatic compare();
        checks++;
        if (grant_valid !== m_valid || (m_valid && grant_qid !== QW'(m_qid))) begin
            errors++;
            $display("FAIL %s: valid=%0b qid=%0d expected valid=%0b qid=%0d at %0t",
                     tag, grant_valid, grant_qid, m_valid, m_qid, $time);
        end
    endtask

    // One clock: model predicts from inputs driven now, DUT samples at posedge,
    // outputs compared at following negedge.
    task automatic step();
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        model_reset();
        tag = "R1";
        compare();
        rst_n = 1;
    endtask

    task automatic set_lvl(input int q, input int lvl);
        queue_prio[q*4 +: 4] = 4'(lvl);
    endtask

    task automatic expect_count(input string t, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", t, act, exp);
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int c0, c1, cz, seed;
        @(negedge clk);
        do_reset();
        repeat (2) step();

        // R6: two equal weights alternate
        tag = "R6";
        queue_prio = '0; set_lvl(2, 4); set_lvl(5, 4);
        q_nonempty = 16'h0024; grant_ack = 1;
        repeat (24) step();

        // R4: static prefix pre-empts weighted, lowest index wins
        do_reset();
        tag = "R4";
        queue_prio = '0; set_lvl(0, 9); set_lvl(1, 9); set_lvl(3, 8);
        q_nonempty = 16'h000a;
        repeat (6) step();
        q_nonempty = 16'h000b;
        repeat (6) step();
        q_nonempty = 16'h0008;
        repeat (6) step();

        // R5: level 9 outside the prefix is weighted
        do_reset();
        tag = "R5";
        queue_prio = '0; set_lvl(0, 2); set_lvl(1, 9);
        q_nonempty = 16'h0003;
        repeat (30) step();

        // R9: grant held without accept
        tag = "R9";
        grant_ack = 0;
        repeat (10) step();
        grant_ack = 1;
        repeat (3) step();

        // R8: idle when only level-0 queues have work, or none at all
        tag = "R8";
        queue_prio = '0; q_nonempty = 16'h00f0;
        repeat (12) step();
        q_nonempty = '0;
        repeat (6) step();

        // R11: priority raised while running
        tag = "R11";
        q_nonempty = 16'h0010;
        repeat (3) step();
        set_lvl(4, 8);
        repeat (6) step();

        // R2 and R3: weight ratio with a level-0 bystander
        do_reset();
        tag = "R2";
        queue_prio = '0; set_lvl(0, 8); set_lvl(1, 1);
        q_nonempty = 16'h0007; grant_ack = 1;
        c0 = 0; c1 = 0; cz = 0;
        repeat (170) begin
            step();
            if (grant_valid && grant_qid == 0) c0++;
            if (grant_valid && grant_qid == 1) c1++;
            if (grant_valid && grant_qid == 2) cz++;
        end
        checks++;
        if (c1 == 0 || c0 < 7 * c1 || c0 > 9 * c1) begin
            errors++;
            $display("FAIL R2: level8=%0d level1=%0d expected ratio 8", c0, c1);
        end
        expect_count("R3", cz, 0);

        // Random phase: levels, prefixes, accept strobes
        do_reset();
        tag = "R3 R7 R10";
        seed = $urandom(32'd20240611);
        for (int n = 0; n < 4000; n++) begin
            if (n % 8 == 0) begin
                for (int q = 0; q < NQ; q++) set_lvl(q, int'($urandom % 16) % 11);
                if ($urandom % 3 == 0) begin
                    set_lvl(0, 9);
                    if ($urandom % 2 == 0) set_lvl(1, 9);
                end
            end
            q_nonempty = NQ'($urandom) & NQ'($urandom);
            grant_ack  = ($urandom % 4) != 0;
            step();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule